// File: doc/BRIEF.md
# Rotating Unit-Element Selector for a 16-Element DAC

This block sits in the feedback path of a multi-bit noise-shaping modulator. A flash quantizer gives a thermometer-coded level each sample. The block decides which of the sixteen unit elements of the feedback DAC to switch on. It does not always take the lowest elements. Instead it keeps one pointer and hands out a contiguous run of elements that starts at the pointer and wraps from the top of the array back to element 0. After each sample the pointer moves past the run it just used. Over time every element carries the same share of the load, so element mismatch turns into shaped noise rather than a fixed error.

The level is found by counting the ones in the input word. A thermometer word with a bubble therefore still produces a valid level. Every clock is one sample. The enable vector and the updated pointer are registered and appear one cycle after the input is captured. The selection path consists of a popcount, a compare-generated mask and a logarithmic barrel rotator, which keeps it short enough for the loop.

Top module: `dwa_selector`

## Requirements
- R1: While `rst_i` is high at a rising edge, the next cycle shows `ptr_o` = 0 and `elem_en_o` = 0.
- R2: The number of set bits in `elem_en_o` equals the number of ones in the `therm_i` captured at the previous rising edge.
- R3: Bit i of `elem_en_o` drives unit element i. The set bits form one run that starts at the pointer value held before the sample and climbs upward, wrapping from element 15 to element 0.
- R4: After each sample, `ptr_o` equals the previous pointer plus the input count, modulo 16. The next run therefore starts right after the last element of the previous run. The input sequence 5, 9, 3, 12 from pointer 0 gives enables 0x001F, 0x3FE0, 0xC001, 0x1FFE and pointers 5, 14, 1, 13.
- R5: An input with no ones enables no element and leaves the pointer unchanged.
- R6: An input with all sixteen ones enables every element and leaves the pointer unchanged.
- R7: A non-contiguous input word is treated as the level given by its count of ones.
- R8: Outputs update every clock with a latency of exactly one cycle from input capture, with no idle cycles between samples.
- R9: Over sixteen consecutive samples of the same count k, each element is enabled exactly k times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Synchronous active-high reset |
| therm_i | input | 16 | Thermometer level from the flash quantizer |
| elem_en_o | output | 16 | Registered unit-element enables, bit i for element i |
| ptr_o | output | 4 | Registered pointer, the first element of the next run |

## Verification
The bench drives the 5, 9, 3, 12 sequence. If the wrap is wrong, the third run would stop at element 15 instead of spilling into element 0, or it would begin at the bottom of the array. A full-scale level tests whether a pointer add that is too narrow or not truncated would shift the pointer or drop elements. A zero level tests whether the pointer stays put. Bubbled inputs catch a selector that reuses the raw thermometer bits instead of counting them. Long constant-level runs would expose any rotation that skips or repeats elements, because the usage count per element would then differ from k.

// File: rtl/dwa_pkg.sv
package dwa_pkg;
  localparam int unsigned DWA_ELEMS = 16;

  // Width needed to hold the values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/dwa_popcount.sv
module dwa_popcount #(
  parameter int unsigned N     = 16,
  parameter int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     bits_i,
  output logic [CNT_W-1:0] count_o
);
  // Pairwise adder tree built level by level
  localparam int unsigned LEVELS = $clog2(N);
  localparam int unsigned PAD    = 1 << LEVELS;

  logic [CNT_W-1:0] node [0:LEVELS][0:PAD-1];

  genvar l, k;
  generate
    for (k = 0; k < PAD; k++) begin : g_leaf
      if (k < N) begin : g_real
        assign node[0][k] = CNT_W'(bits_i[k]);
      end else begin : g_pad
        assign node[0][k] = '0;
      end
    end
    for (l = 0; l < LEVELS; l++) begin : g_lvl
      for (k = 0; k < (PAD >> (l + 1)); k++) begin : g_add
        assign node[l+1][k] = node[l][2*k] + node[l][2*k+1];
      end
      for (k = (PAD >> (l + 1)); k < PAD; k++) begin : g_fill
        assign node[l+1][k] = '0;
      end
    end
  endgenerate

  assign count_o = node[LEVELS][0];
endmodule

// File: rtl/dwa_lowmask.sv
module dwa_lowmask #(
  parameter int unsigned N          = 16,
  parameter int unsigned CNT_W      = $clog2(N + 1),
  parameter bit          SORT_BUBBLES = 1'b1
) (
  input  logic [N-1:0]     therm_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [N-1:0]     mask_o
);
  genvar i;
  generate
    if (SORT_BUBBLES) begin : g_sorted
      // Regenerate a clean low-justified mask from the count
      for (i = 0; i < N; i++) begin : g_bit
        assign mask_o[i] = (count_i > CNT_W'(i));
      end
    end else begin : g_raw
      // Trust the quantizer: its word is already a low mask
      assign mask_o = therm_i;
    end
  endgenerate
endmodule

// File: rtl/dwa_rotator.sv
module dwa_rotator #(
  parameter int unsigned N     = 16,
  parameter int unsigned PTR_W = $clog2(N)
) (
  input  logic [N-1:0]     data_i,
  input  logic [PTR_W-1:0] amount_i,
  output logic [N-1:0]     data_o
);
  // Log-depth rotate-left: bit i moves to (i + amount) mod N
  logic [N-1:0] stage [0:PTR_W];
  assign stage[0] = data_i;

  genvar s;
  generate
    for (s = 0; s < PTR_W; s++) begin : g_stage
      localparam int unsigned SH = 1 << s;
      logic [N-1:0] rotated;
      assign rotated = {stage[s][N-1-SH:0], stage[s][N-1:N-SH]};
      assign stage[s+1] = amount_i[s] ? rotated : stage[s];
    end
  endgenerate

  assign data_o = stage[PTR_W];
endmodule

// File: rtl/dwa_selector.sv
module dwa_selector #(
  parameter int unsigned N_ELEM       = dwa_pkg::DWA_ELEMS,
  parameter bit          SORT_BUBBLES = 1'b1,
  parameter int unsigned PTR_W        = $clog2(N_ELEM)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [N_ELEM-1:0] therm_i,
  output logic [N_ELEM-1:0] elem_en_o,
  output logic [PTR_W-1:0]  ptr_o
);
  localparam int unsigned CNT_W = dwa_pkg::cnt_width(N_ELEM);

  logic [CNT_W-1:0]  level;
  logic [N_ELEM-1:0] low_mask;
  logic [N_ELEM-1:0] sel_next;
  logic [PTR_W-1:0]  ptr_q;
  logic [N_ELEM-1:0] en_q;

  dwa_popcount #(.N(N_ELEM), .CNT_W(CNT_W)) u_count (
    .bits_i  (therm_i),
    .count_o (level)
  );

  dwa_lowmask #(.N(N_ELEM), .CNT_W(CNT_W), .SORT_BUBBLES(SORT_BUBBLES)) u_mask (
    .therm_i (therm_i),
    .count_i (level),
    .mask_o  (low_mask)
  );

  dwa_rotator #(.N(N_ELEM), .PTR_W(PTR_W)) u_rot (
    .data_i   (low_mask),
    .amount_i (ptr_q),
    .data_o   (sel_next)
  );

  // Pointer wraps naturally: the count is truncated to the pointer width
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ptr_q <= '0;
      en_q  <= '0;
    end else begin
      ptr_q <= ptr_q + level[PTR_W-1:0];
      en_q  <= sel_next;
    end
  end

  assign elem_en_o = en_q;
  assign ptr_o     = ptr_q;

  AST_RESET_STATE: assert property (@(posedge clk_i)
    rst_i |=> (ptr_q == '0 && en_q == '0)); // R1

  AST_EN_COUNT: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ($countones(en_q) == int'($past(level)))); // R2

  AST_RUN_START: assert property (@(posedge clk_i) disable iff (rst_i)
    (level != '0) |=> en_q[$past(ptr_q)]); // R3

  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (ptr_q == PTR_W'($past(ptr_q) + $past(level[PTR_W-1:0])))); // R4

  AST_ZERO_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
    (level == '0) |=> (en_q == '0 && $stable(ptr_q))); // R5

  AST_FULL_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
    (level == CNT_W'(N_ELEM)) |=> ((&en_q) && $stable(ptr_q))); // R6
endmodule

// File: tb/tb_dwa_selector.sv
module tb_dwa_selector;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  therm;
  logic [N-1:0]  en;
  logic [3:0]    ptr;

  int n_checks = 0;
  int n_fail   = 0;
  int mdl_ptr  = 0;
  int usage [0:N-1];

  always #2.5 clk = ~clk;

  dwa_selector dut (
    .clk_i     (clk),
    .rst_i     (rst),
    .therm_i   (therm),
    .elem_en_o (en),
    .ptr_o     (ptr)
  );

  function automatic logic [N-1:0] run_mask(input int start, input int cnt);
    logic [N-1:0] m = '0;
    for (int i = 0; i < cnt; i++) m[(start + i) % N] = 1'b1;
    return m;
  endfunction

  function automatic logic [N-1:0] thermo(input int cnt);
    logic [N-1:0] m = '0;
    for (int i = 0; i < cnt; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called right after a falling edge; returns right after the next one
  task automatic apply(input logic [N-1:0] word, input string req);
    int cnt = $countones(word);
    logic [N-1:0] exp_en = run_mask(mdl_ptr, cnt);
    therm = word;
    @(negedge clk);
    mdl_ptr = (mdl_ptr + cnt) % N;
    check({req, " enables"}, 32'(en), 32'(exp_en));
    check({req, " pointer"}, 32'(ptr), 32'(mdl_ptr));
  endtask

  task automatic do_reset();
    rst = 1'b1; therm = '0;
    @(negedge clk); @(negedge clk);
    check("R1 ptr after reset", 32'(ptr), 0);
    check("R1 en after reset", 32'(en), 0);
    rst = 1'b0; mdl_ptr = 0;
  endtask

  task automatic t_sequence();
    // R4 R3 R2: 5,9,3,12 from pointer 0
    apply(thermo(5),  "R4 seq5");
    check("R3 seq5 exact", 32'(en), 32'h001F);
    apply(thermo(9),  "R4 seq9");
    check("R3 seq9 exact", 32'(en), 32'h3FE0);
    apply(thermo(3),  "R4 seq3 wrap");
    check("R3 seq3 wrap exact", 32'(en), 32'hC001);
    apply(thermo(12), "R4 seq12");
    check("R3 seq12 exact", 32'(en), 32'h1FFE);
    check("R4 final ptr", 32'(ptr), 13);
  endtask

  task automatic t_zero_full();
    apply(thermo(0),  "R5 zero level");
    check("R5 none enabled", 32'(en), 0);
    apply(thermo(16), "R6 full level");
    check("R6 all enabled", 32'(en), 32'hFFFF);
    check("R6 ptr unchanged", 32'(ptr), 13);
  endtask

  task automatic t_bubbles();
    apply(16'b0000_0000_0010_1011, "R7 bubble4");
    apply(16'b1000_0000_0000_0001, "R7 split2");
    apply(16'b0101_0101_0101_0101, "R7 alt8");
  endtask

  task automatic t_back_to_back();
    // R8: a fresh level every clock
    for (int k = 0; k < 40; k++) apply(thermo((k * 7 + 3) % 17), "R8 stream");
  endtask

  task automatic t_usage(input int k);
    for (int i = 0; i < N; i++) usage[i] = 0;
    for (int s = 0; s < N; s++) begin
      apply(thermo(k), "R9 run");
      for (int i = 0; i < N; i++) usage[i] += int'(en[i]);
    end
    for (int i = 0; i < N; i++) check("R9 per-element usage", 32'(usage[i]), 32'(k));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    rst = 1'b1; therm = '0;
    @(negedge clk);
    do_reset();
    t_sequence();
    t_zero_full();
    t_bubbles();
    t_back_to_back();
    t_usage(3);
    t_usage(5);
    apply(thermo(7), "R1 pre-reset");
    do_reset();
    apply(thermo(2), "R1 restart from zero");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule